// File: doc/BRIEF.md
# Loop requeue stage controller

This block sits in front of a circular instruction FIFO. It merges two instruction streams into that FIFO. The first is an enqueue stream that carries newly dispatched instructions. The second is a recirculate stream that carries instructions coming back from execution. A two-state controller runs the loop. In the loading state it admits a loop body from the enqueue stream and throws away stale recirculated work. In the repeating state it feeds the recirculated instructions straight back into the FIFO. An executed abort ends the repeating state.

Every stream uses a valid/ready handshake. Each beat carries a 25-bit instruction word and a 2-bit decoded class. An instruction moves across an interface only in a cycle where both valid and ready are high. The execution stage sends two signals for abort: a strobe saying an abort reached execution, and a flag saying its predicate held. The routing is purely combinational. The only storage is the state bit.

Top module: `loop_requeue_ctrl`

## Requirements
- R1: After a synchronous active-low reset the controller is in the loading state, so an enqueued non-tail instruction is offered at the output in the first cycle after reset.
- R2: In the loading state, an enqueue beat whose class is not tail appears at the output with the same word and class, and enq_ready equals out_ready for it.
- R3: In the loading state, a recirculate beat whose class is not head is accepted (rec_ready high) whatever the value of out_ready, and it never appears at the output.
- R4: In the loading state, an enqueue tail with no recirculate head present holds enq_ready low and drives nothing to the output, cycle after cycle.
- R5: In the loading state, a recirculate head with no enqueue tail present holds rec_ready low. An enqueue non-tail beat still passes in that same cycle.
- R6: When an enqueue tail and a recirculate head are valid together in the loading state, both readies go high, out_valid stays low, and the controller is in the repeating state from the next cycle.
- R7: In the repeating state enq_ready is always low. out_valid, out_instr and out_class follow the recirculate input for every class, including head and tail, and rec_ready equals out_ready.
- R8: In the repeating state, an abort strobe with its predicate flag high returns the controller to the loading state from the next cycle.
- R9: An abort strobe with its predicate flag low leaves the state unchanged.
- R10: The class encoding is 2'b00 other, 2'b01 head, 2'b10 tail. Code 2'b11 is handled as other.
- R11: No ready is raised on an input whose valid is low, and out_valid is never high unless the selected source is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enq_valid | input | 1 | Enqueue beat present |
| enq_ready | output | 1 | Enqueue beat taken this cycle |
| enq_instr | input | 25 | Enqueue instruction word |
| enq_class | input | 2 | Enqueue class (00 other, 01 head, 10 tail) |
| rec_valid | input | 1 | Recirculate beat present |
| rec_ready | output | 1 | Recirculate beat taken this cycle |
| rec_instr | input | 25 | Recirculate instruction word |
| rec_class | input | 2 | Recirculate class |
| out_valid | output | 1 | Beat offered to the instruction FIFO |
| out_ready | input | 1 | FIFO can take the beat |
| out_instr | output | 25 | Instruction word offered to the FIFO |
| out_class | output | 2 | Class of the offered word |
| abort_valid | input | 1 | An abort reached the execution stage |
| abort_taken | input | 1 | That abort's predicate held |

## Verification
The bench covers each stall on its own and checks that it stays in place over several cycles. A design that let either marker drain alone would start a loop with half of its boundary missing. The bench also presents both markers together and checks that neither one is forwarded. A leaky design would push a head or tail into the FIFO body. In the repeating state the bench offers enqueue traffic and sends back-pressure, and checks that enqueue is locked out and that head and tail words pass through unchanged. Finally it fires an abort whose predicate failed and checks that the loop keeps running, so a design that ignored the predicate flag would drop out of the loop.

// File: rtl/requeue_pkg.sv
// Shared types for the loop requeue stage.
// Assumes the class code is produced by an upstream decoder.
package requeue_pkg;
    localparam int CLS_W = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_OTHER = 2'b00,
        CLS_HEAD  = 2'b01,
        CLS_TAIL  = 2'b10,
        CLS_SPARE = 2'b11
    } instr_cls_e;

    typedef enum logic {
        ST_LOADING   = 1'b0,
        ST_REPEATING = 1'b1
    } rq_state_e;
endpackage

// File: rtl/requeue_marker_decode.sv
// Turns a class code into head/tail marker flags.
// Assumes the spare code means an ordinary instruction.
module requeue_marker_decode
    import requeue_pkg::*;
(
    input  logic [CLS_W-1:0] cls,
    output logic             is_head,
    output logic             is_tail
);
    // Compare the class against the two loop markers.
    always_comb begin
        is_head = (instr_cls_e'(cls) == CLS_HEAD);
        is_tail = (instr_cls_e'(cls) == CLS_TAIL);
    end
endmodule

// File: rtl/requeue_state_fsm.sv
// Holds the loading/repeating state of the requeue stage.
// Assumes loop_enter is only raised while loading, and abort strobes are single-cycle.
module requeue_state_fsm
    import requeue_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      loop_enter,
    input  logic      abort_valid,
    input  logic      abort_taken,
    output rq_state_e state
);
    // Next-state register: enter on the marker pair, leave on an executed abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_LOADING;
        end else begin
            case (state)
                ST_LOADING:   if (loop_enter) state <= ST_REPEATING;
                ST_REPEATING: if (abort_valid && abort_taken) state <= ST_LOADING;
                default:      state <= ST_LOADING;
            endcase
        end
    end

    AST_ENTER_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOADING && loop_enter) |=> state == ST_REPEATING); // R6
    AST_ABORT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REPEATING && abort_valid && abort_taken) |=> state == ST_LOADING); // R8
    AST_ABORT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REPEATING && abort_valid && !abort_taken) |=> state == ST_REPEATING); // R9
endmodule

// File: rtl/requeue_router.sv
// Combinational steering of the enqueue and recirculate streams to the FIFO port.
// Assumes the state comes from requeue_state_fsm, and that the FIFO port keeps no
// registers, so every decision is made within the cycle.
module requeue_router
    import requeue_pkg::*;
#(
    parameter int INSTR_W = 25
) (
    input  logic               clk,
    input  logic               rst_n,
    input  rq_state_e          state,
    input  logic               enq_valid,
    input  logic               enq_tail,
    input  logic [INSTR_W-1:0] enq_instr,
    input  logic [CLS_W-1:0]   enq_class,
    input  logic               rec_valid,
    input  logic               rec_head,
    input  logic [INSTR_W-1:0] rec_instr,
    input  logic [CLS_W-1:0]   rec_class,
    input  logic               out_ready,
    output logic               enq_ready,
    output logic               rec_ready,
    output logic               out_valid,
    output logic [INSTR_W-1:0] out_instr,
    output logic [CLS_W-1:0]   out_class,
    output logic               loop_enter
);
    // Pick the source and the handshakes for the current state.
    always_comb begin
        enq_ready  = 1'b0;
        rec_ready  = 1'b0;
        out_valid  = 1'b0;
        out_instr  = enq_instr;
        out_class  = enq_class;
        loop_enter = 1'b0;
        if (state == ST_LOADING) begin
            loop_enter = enq_valid && enq_tail && rec_valid && rec_head;
            out_valid  = enq_valid && !enq_tail;
            enq_ready  = loop_enter || (enq_valid && !enq_tail && out_ready);
            rec_ready  = loop_enter || (rec_valid && !rec_head);
        end else begin
            out_valid  = rec_valid;
            out_instr  = rec_instr;
            out_class  = rec_class;
            rec_ready  = rec_valid && out_ready;
        end
    end

    AST_REPEAT_NO_ENQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REPEATING) |-> !enq_ready); // R7
    AST_TAIL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOADING && enq_valid && enq_tail && !(rec_valid && rec_head)) |-> !enq_ready && !out_valid); // R4
    AST_HEAD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOADING && rec_valid && rec_head && !(enq_valid && enq_tail)) |-> !rec_ready); // R5
    AST_NO_MARKER_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOADING && out_valid) |-> !enq_tail); // R6
    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (!enq_ready || enq_valid) && (!rec_ready || rec_valid)); // R11
endmodule

// File: rtl/loop_requeue_ctrl.sv
// Top of the loop requeue stage. It merges the enqueue and recirculate
// instruction streams into the circular instruction FIFO, under a
// two-state loop controller.
// Assumes the instructions are already classified and that abort
// strobes come from the execution stage.
module loop_requeue_ctrl
    import requeue_pkg::*;
#(
    parameter int INSTR_W = 25
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enq_valid,
    output logic               enq_ready,
    input  logic [INSTR_W-1:0] enq_instr,
    input  logic [1:0]         enq_class,
    input  logic               rec_valid,
    output logic               rec_ready,
    input  logic [INSTR_W-1:0] rec_instr,
    input  logic [1:0]         rec_class,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [INSTR_W-1:0] out_instr,
    output logic [1:0]         out_class,
    input  logic               abort_valid,
    input  logic               abort_taken
);
    rq_state_e state;
    logic      loop_enter;
    logic      enq_head_unused;
    logic      enq_tail;
    logic      rec_head;
    logic      rec_tail_unused;

    requeue_marker_decode u_enq_dec (
        .cls     (enq_class),
        .is_head (enq_head_unused),
        .is_tail (enq_tail)
    );

    requeue_marker_decode u_rec_dec (
        .cls     (rec_class),
        .is_head (rec_head),
        .is_tail (rec_tail_unused)
    );

    requeue_state_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .loop_enter  (loop_enter),
        .abort_valid (abort_valid),
        .abort_taken (abort_taken),
        .state       (state)
    );

    requeue_router #(.INSTR_W(INSTR_W)) u_router (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .enq_valid  (enq_valid),
        .enq_tail   (enq_tail),
        .enq_instr  (enq_instr),
        .enq_class  (enq_class),
        .rec_valid  (rec_valid),
        .rec_head   (rec_head),
        .rec_instr  (rec_instr),
        .rec_class  (rec_class),
        .out_ready  (out_ready),
        .enq_ready  (enq_ready),
        .rec_ready  (rec_ready),
        .out_valid  (out_valid),
        .out_instr  (out_instr),
        .out_class  (out_class),
        .loop_enter (loop_enter)
    );

    AST_OUT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (enq_valid || rec_valid)); // R11
endmodule

// File: tb/loop_requeue_ctrl_tb.sv
// Directed bench for loop_requeue_ctrl. Inputs are driven on the falling edge
// and outputs sampled 1 ns later.
module loop_requeue_ctrl_tb;
    localparam int W = 25;
    localparam logic [1:0] C_OTH = 2'b00, C_HEAD = 2'b01, C_TAIL = 2'b10, C_SPR = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enq_valid = 0, rec_valid = 0, out_ready = 0, abort_valid = 0, abort_taken = 0;
    logic [W-1:0] enq_instr = '0, rec_instr = '0;
    logic [1:0] enq_class = C_OTH, rec_class = C_OTH;
    logic enq_ready, rec_ready, out_valid;
    logic [W-1:0] out_instr;
    logic [1:0] out_class;
    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    loop_requeue_ctrl #(.INSTR_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_instr(enq_instr), .enq_class(enq_class),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_instr(rec_instr), .rec_class(rec_class),
        .out_valid(out_valid), .out_ready(out_ready), .out_instr(out_instr), .out_class(out_class),
        .abort_valid(abort_valid), .abort_taken(abort_taken)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        enq_valid = 0; rec_valid = 0; abort_valid = 0; abort_taken = 0;
        enq_class = C_OTH; rec_class = C_OTH;
    endtask

    // Step to the next falling edge, where new stimulus is applied.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        step(); rst_n = 0; idle(); out_ready = 1;
        repeat (3) step();
        rst_n = 1;
        enq_valid = 1; enq_class = C_OTH; enq_instr = 25'h0ABCDE;
        #1;
        chk("R1 out_valid after reset", 32'(out_valid), 1);
        chk("R1 enq_ready after reset", 32'(enq_ready), 1);
        chk("R1 out_instr after reset", 32'(out_instr), 32'h0ABCDE);
    endtask

    task automatic t_forward();
        step(); idle(); out_ready = 0;
        enq_valid = 1; enq_class = C_OTH; enq_instr = 25'h1555555;
        #1;
        chk("R2 out_valid", 32'(out_valid), 1);
        chk("R2 enq_ready under backpressure", 32'(enq_ready), 0);
        chk("R2 out_instr", 32'(out_instr), 32'h1555555);
        step(); enq_class = C_SPR; enq_instr = 25'h0000F0; out_ready = 1;
        #1;
        chk("R10 spare code forwarded", 32'(out_valid), 1);
        chk("R10 spare code out_class", 32'(out_class), 32'(C_SPR));
        chk("R2 enq_ready with ready", 32'(enq_ready), 1);
    endtask

    task automatic t_rec_drop();
        step(); idle(); out_ready = 0;
        rec_valid = 1; rec_class = C_TAIL; rec_instr = 25'h0123;
        #1;
        chk("R3 rec_ready on drop", 32'(rec_ready), 1);
        chk("R3 dropped not at output", 32'(out_valid), 0);
        step(); idle(); out_ready = 1;
        #1;
        chk("R11 idle enq_ready", 32'(enq_ready), 0);
        chk("R11 idle rec_ready", 32'(rec_ready), 0);
        chk("R11 idle out_valid", 32'(out_valid), 0);
    endtask

    task automatic t_tail_stall();
        step(); idle(); out_ready = 1;
        enq_valid = 1; enq_class = C_TAIL; enq_instr = 25'h0777;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk("R4 tail stalls enq_ready", 32'(enq_ready), 0);
            chk("R4 tail not output", 32'(out_valid), 0);
            step();
        end
    endtask

    task automatic t_head_stall();
        idle(); out_ready = 1;
        rec_valid = 1; rec_class = C_HEAD;
        for (int i = 0; i < 2; i++) begin
            #1;
            chk("R5 head stalls rec_ready", 32'(rec_ready), 0);
            step();
        end
        enq_valid = 1; enq_class = C_OTH; enq_instr = 25'h0BEEF;
        #1;
        chk("R5 rec_ready with enq other", 32'(rec_ready), 0);
        chk("R5 enq passes beside head", 32'(enq_ready), 1);
        chk("R5 out_instr beside head", 32'(out_instr), 32'h0BEEF);
    endtask

    task automatic t_enter_and_repeat();
        step(); idle(); out_ready = 0;
        enq_valid = 1; enq_class = C_TAIL; rec_valid = 1; rec_class = C_HEAD;
        #1;
        chk("R6 enq_ready on pair", 32'(enq_ready), 1);
        chk("R6 rec_ready on pair", 32'(rec_ready), 1);
        chk("R6 pair not output", 32'(out_valid), 0);
        step(); idle(); out_ready = 1;
        enq_valid = 1; enq_class = C_OTH;
        rec_valid = 1; rec_class = C_OTH; rec_instr = 25'h1F0F0F0;
        #1;
        chk("R6 R7 enq locked out", 32'(enq_ready), 0);
        chk("R7 out_valid follows rec", 32'(out_valid), 1);
        chk("R7 out_instr from rec", 32'(out_instr), 32'h1F0F0F0);
        chk("R7 rec_ready follows out_ready", 32'(rec_ready), 1);
        step(); out_ready = 0; rec_class = C_HEAD; rec_instr = 25'h0000AA;
        #1;
        chk("R7 head passes through", 32'(out_class), 32'(C_HEAD));
        chk("R7 rec_ready under backpressure", 32'(rec_ready), 0);
        step(); out_ready = 1; rec_class = C_TAIL;
        #1;
        chk("R7 tail passes through", 32'(out_valid), 1);
        chk("R7 tail out_class", 32'(out_class), 32'(C_TAIL));
    endtask

    task automatic t_abort();
        step(); idle(); out_ready = 1;
        abort_valid = 1; abort_taken = 0;
        step(); idle(); enq_valid = 1; enq_class = C_OTH;
        #1;
        chk("R9 failed abort keeps repeating", 32'(enq_ready), 0);
        step(); idle(); abort_valid = 1; abort_taken = 1;
        step(); idle(); enq_valid = 1; enq_class = C_OTH; enq_instr = 25'h0C0DE;
        #1;
        chk("R8 abort returns to loading", 32'(enq_ready), 1);
        chk("R8 loading forwards enq", 32'(out_instr), 32'h0C0DE);
        step(); idle();
    endtask

    initial begin
        t_reset();
        t_forward();
        t_rec_drop();
        t_tail_stall();
        t_head_stall();
        t_enter_and_repeat();
        t_abort();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule